// File: doc/BRIEF.md
# Register Window Pointer Unit

This unit keeps the current window pointer of a windowed integer register file, together with the control fields of the 32-bit processor status word. The decoder sends it one command per cycle. Each command is a strobe plus an opcode and a 32-bit data word. The commands are:

- call-side window entry (save)
- window exit (restore)
- return from trap
- status-word write
- write to the per-window invalid mask

The number of implemented windows comes in on `win_cnt_i`. All pointer arithmetic wraps modulo that count.

A move that would land on a window whose invalid-mask bit is set does not change any state. Instead it reports an overflow trap for an entry or an underflow trap for an exit. Return from trap is only legal while traps are disabled. When it succeeds it does three things:

- re-enables traps
- restores the supervisor bit from its saved copy
- moves the window like an exit

A status-word write that names a window outside the configured count is rejected as illegal. The packed status word is always available on `psw_o`. Every trap is reported as a one-cycle pulse with a two-bit code in the cycle after the command.

Top module: `wptr_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, the pointer is 0 and the supervisor bit is 1. Trap-enable, previous-supervisor, FP-enable, interrupt level, condition codes and the whole invalid mask are 0, and `trap_valid_o` is 0.
- R2: A save (opcode 0) sets the pointer to pointer-1 in the cycle after the command, and a pointer of 0 becomes `win_cnt_i`-1.
- R3: A restore (opcode 1) sets the pointer to pointer+1 in the cycle after the command, and `win_cnt_i`-1 becomes 0.
- R4: If the invalid-mask bit at the target window is set, a save reports overflow (code 2) and a restore reports underflow (code 3). The pointer is left unchanged.
- R5: A return from trap (opcode 2) while trap-enable is 1 reports illegal (code 1) and changes no state. This takes priority over an underflow on the same command.
- R6: A return from trap while trap-enable is 0 sets trap-enable to 1, copies previous-supervisor into supervisor and advances the pointer as in R3. If the target window's invalid-mask bit is set, it instead reports underflow (code 3) and changes nothing.
- R7: A status-word write (opcode 3) loads the condition codes from data bits 23:20, FP-enable from bit 12, interrupt level from bits 11:8, supervisor from bit 7, previous-supervisor from bit 6, trap-enable from bit 5 and the pointer from bits 4:0. If bits 4:0 are not below `win_cnt_i`, it reports illegal (code 1) and changes nothing.
- R8: `psw_o` carries the VERSION parameter in bits 31:24, then the condition codes at 23:20, FP-enable at 12, interrupt level at 11:8, supervisor at 7, previous-supervisor at 6, trap-enable at 5 and the pointer at 4:0. Bits 19:13 read 0.
- R9: A mask write (opcode 4) loads the invalid mask from data bits MAX_WINDOWS-1:0. Bit n guards window n.
- R10: `trap_valid_o` is high for exactly the cycle after a trapping command, and `trap_code_o` holds the code in that cycle. In every other cycle both are 0.
- R11: Opcodes 5 to 7, and any cycle with `cmd_valid_i` low, change no state and raise no trap.
- R12: Wrapping and the range check follow the current `win_cnt_i` (any value from 2 to MAX_WINDOWS), not the parameter maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| wdata_i | input | 32 | Write data for status-word and mask writes |
| win_cnt_i | input | $clog2(MAX_WINDOWS)+1 | Number of implemented windows |
| cwp_o | output | $clog2(MAX_WINDOWS) | Current window pointer |
| psw_o | output | 32 | Packed status word |
| trap_valid_o | output | 1 | Trap pulse |
| trap_code_o | output | 2 | Trap code: 0 none, 1 illegal, 2 overflow, 3 underflow |

## Verification
A return from trap performs two checks on the same command: the trap-enable check and the window-underflow check. Both can fail at once. The bench sets trap-enable through a status-word write and marks the target window invalid. It then expects the illegal code rather than underflow, with the status word unchanged. The opposite combination is also tested: traps disabled and the target window invalid. It must report underflow and leave both the supervisor bit and trap-enable as they were.

// File: rtl/wptr_pkg.sv
package wptr_pkg;

  localparam logic [2:0] OP_SAVE    = 3'd0;
  localparam logic [2:0] OP_RESTORE = 3'd1;
  localparam logic [2:0] OP_RETT    = 3'd2;
  localparam logic [2:0] OP_WR_PSW  = 3'd3;
  localparam logic [2:0] OP_WR_WIM  = 3'd4;

  typedef enum logic [1:0] {
    TRAP_NONE      = 2'd0,
    TRAP_ILLEGAL   = 2'd1,
    TRAP_OVERFLOW  = 2'd2,
    TRAP_UNDERFLOW = 2'd3
  } trap_e;

  // status word field positions
  localparam int PSW_CWP_W   = 5;
  localparam int PSW_ET_BIT  = 5;
  localparam int PSW_PS_BIT  = 6;
  localparam int PSW_S_BIT   = 7;
  localparam int PSW_PIL_LSB = 8;
  localparam int PSW_EF_BIT  = 12;
  localparam int PSW_ICC_LSB = 20;
  localparam int PSW_VER_LSB = 24;

  typedef struct packed {
    logic [3:0] icc;
    logic       ef;
    logic [3:0] pil;
    logic       s;
    logic       ps;
    logic       et;
  } psw_flags_t;

  localparam psw_flags_t FLAGS_RESET = '{icc: 4'h0, ef: 1'b0, pil: 4'h0,
                                         s: 1'b1, ps: 1'b0, et: 1'b0};

endpackage

// File: rtl/wptr_step.sv
module wptr_step #(
  parameter  int MAX_WINDOWS = 8,
  localparam int CW = $clog2(MAX_WINDOWS),
  localparam int NW = CW + 1
) (
  input  logic [CW-1:0] cwp_i,
  input  logic [NW-1:0] win_cnt_i,
  output logic [CW-1:0] dec_o,
  output logic [CW-1:0] inc_o
);

  logic [NW-1:0] cnt_m1;
  logic [NW-1:0] up;

  assign cnt_m1 = win_cnt_i - NW'(1);
  assign up     = {1'b0, cwp_i} + NW'(1);

  assign dec_o = (cwp_i == '0) ? cnt_m1[CW-1:0] : cwp_i - CW'(1);
  assign inc_o = (up >= win_cnt_i) ? '0 : up[CW-1:0];

endmodule

// File: rtl/wptr_psw_codec.sv
module wptr_psw_codec
  import wptr_pkg::*;
#(
  parameter  int         MAX_WINDOWS = 8,
  parameter  logic [7:0] VERSION     = 8'h00,
  localparam int         CW = $clog2(MAX_WINDOWS)
) (
  input  psw_flags_t           flags_i,
  input  logic [CW-1:0]        cwp_i,
  output logic [31:0]          word_o,
  input  logic [31:0]          word_i,
  output psw_flags_t           flags_o,
  output logic [PSW_CWP_W-1:0] cwp_field_o
);

  logic [PSW_CWP_W-1:0] cwp_ext;
  logic                 unused_bits;

  generate
    if (CW < PSW_CWP_W) begin : g_pad
      assign cwp_ext = {{(PSW_CWP_W-CW){1'b0}}, cwp_i};
    end else begin : g_full
      assign cwp_ext = cwp_i;
    end
  endgenerate

  always_comb begin
    word_o                              = '0;
    word_o[PSW_VER_LSB +: 8]            = VERSION;
    word_o[PSW_ICC_LSB +: 4]            = flags_i.icc;
    word_o[PSW_EF_BIT]                  = flags_i.ef;
    word_o[PSW_PIL_LSB +: 4]            = flags_i.pil;
    word_o[PSW_S_BIT]                   = flags_i.s;
    word_o[PSW_PS_BIT]                  = flags_i.ps;
    word_o[PSW_ET_BIT]                  = flags_i.et;
    word_o[PSW_CWP_W-1:0]               = cwp_ext;
  end

  always_comb begin
    flags_o.icc = word_i[PSW_ICC_LSB +: 4];
    flags_o.ef  = word_i[PSW_EF_BIT];
    flags_o.pil = word_i[PSW_PIL_LSB +: 4];
    flags_o.s   = word_i[PSW_S_BIT];
    flags_o.ps  = word_i[PSW_PS_BIT];
    flags_o.et  = word_i[PSW_ET_BIT];
  end

  assign cwp_field_o = word_i[PSW_CWP_W-1:0];
  // version and reserved bits are read-only
  assign unused_bits = ^{word_i[31:24], word_i[19:13]};

endmodule

// File: rtl/wptr_ctrl.sv
module wptr_ctrl
  import wptr_pkg::*;
#(
  parameter  int MAX_WINDOWS = 8,
  localparam int CW = $clog2(MAX_WINDOWS),
  localparam int NW = CW + 1
) (
  input  logic                   cmd_valid_i,
  input  logic [2:0]             cmd_op_i,
  input  logic [MAX_WINDOWS-1:0] wim_wdata_i,
  input  logic [NW-1:0]          win_cnt_i,
  input  logic [CW-1:0]          cwp_q_i,
  input  psw_flags_t             flags_q_i,
  input  logic [MAX_WINDOWS-1:0] wim_q_i,
  input  logic [CW-1:0]          dec_i,
  input  logic [CW-1:0]          inc_i,
  input  psw_flags_t             wr_flags_i,
  input  logic [PSW_CWP_W-1:0]   wr_cwp_i,
  output logic [CW-1:0]          cwp_d_o,
  output psw_flags_t             flags_d_o,
  output logic [MAX_WINDOWS-1:0] wim_d_o,
  output trap_e                  trap_d_o
);

  logic [5:0] wr_cwp6;
  logic [5:0] cnt6;
  logic       wr_cwp_bad;

  assign wr_cwp6    = 6'(wr_cwp_i);
  assign cnt6       = 6'(win_cnt_i);
  assign wr_cwp_bad = (wr_cwp6 >= cnt6);

  always_comb begin
    cwp_d_o   = cwp_q_i;
    flags_d_o = flags_q_i;
    wim_d_o   = wim_q_i;
    trap_d_o  = TRAP_NONE;
    if (cmd_valid_i) begin
      case (cmd_op_i)
        OP_SAVE: begin
          if (wim_q_i[dec_i]) trap_d_o = TRAP_OVERFLOW;
          else                cwp_d_o  = dec_i;
        end
        OP_RESTORE: begin
          if (wim_q_i[inc_i]) trap_d_o = TRAP_UNDERFLOW;
          else                cwp_d_o  = inc_i;
        end
        OP_RETT: begin
          // enable check outranks the window check
          if (flags_q_i.et) begin
            trap_d_o = TRAP_ILLEGAL;
          end else if (wim_q_i[inc_i]) begin
            trap_d_o = TRAP_UNDERFLOW;
          end else begin
            cwp_d_o      = inc_i;
            flags_d_o.et = 1'b1;
            flags_d_o.s  = flags_q_i.ps;
          end
        end
        OP_WR_PSW: begin
          if (wr_cwp_bad) begin
            trap_d_o = TRAP_ILLEGAL;
          end else begin
            flags_d_o = wr_flags_i;
            cwp_d_o   = wr_cwp_i[CW-1:0];
          end
        end
        OP_WR_WIM: wim_d_o = wim_wdata_i;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wptr_unit.sv
module wptr_unit
  import wptr_pkg::*;
#(
  parameter  int         MAX_WINDOWS = 8,
  parameter  logic [7:0] VERSION     = 8'h00,
  localparam int         CW = $clog2(MAX_WINDOWS),
  localparam int         NW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [31:0]   wdata_i,
  input  logic [NW-1:0] win_cnt_i,
  output logic [CW-1:0] cwp_o,
  output logic [31:0]   psw_o,
  output logic          trap_valid_o,
  output logic [1:0]    trap_code_o
);

  logic [CW-1:0]          cwp_q, cwp_d, dec, inc;
  psw_flags_t             flags_q, flags_d, wr_flags;
  logic [MAX_WINDOWS-1:0] wim_q, wim_d;
  logic [PSW_CWP_W-1:0]   wr_cwp;
  trap_e                  trap_d, trap_q;
  logic                   trap_valid_q;

  wptr_step #(.MAX_WINDOWS(MAX_WINDOWS)) u_step (
    .cwp_i     (cwp_q),
    .win_cnt_i (win_cnt_i),
    .dec_o     (dec),
    .inc_o     (inc)
  );

  wptr_psw_codec #(.MAX_WINDOWS(MAX_WINDOWS), .VERSION(VERSION)) u_codec (
    .flags_i     (flags_q),
    .cwp_i       (cwp_q),
    .word_o      (psw_o),
    .word_i      (wdata_i),
    .flags_o     (wr_flags),
    .cwp_field_o (wr_cwp)
  );

  wptr_ctrl #(.MAX_WINDOWS(MAX_WINDOWS)) u_ctrl (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .wim_wdata_i (wdata_i[MAX_WINDOWS-1:0]),
    .win_cnt_i   (win_cnt_i),
    .cwp_q_i     (cwp_q),
    .flags_q_i   (flags_q),
    .wim_q_i     (wim_q),
    .dec_i       (dec),
    .inc_i       (inc),
    .wr_flags_i  (wr_flags),
    .wr_cwp_i    (wr_cwp),
    .cwp_d_o     (cwp_d),
    .flags_d_o   (flags_d),
    .wim_d_o     (wim_d),
    .trap_d_o    (trap_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q        <= '0;
      flags_q      <= FLAGS_RESET;
      wim_q        <= '0;
      trap_q       <= TRAP_NONE;
      trap_valid_q <= 1'b0;
    end else begin
      cwp_q        <= cwp_d;
      flags_q      <= flags_d;
      wim_q        <= wim_d;
      trap_q       <= trap_d;
      trap_valid_q <= (trap_d != TRAP_NONE);
    end
  end

  assign cwp_o        = cwp_q;
  assign trap_valid_o = trap_valid_q;
  assign trap_code_o  = trap_q;

endmodule

// File: rtl/wptr_unit_chk.sv
module wptr_unit_chk
  import wptr_pkg::*;
#(
  parameter  int MAX_WINDOWS = 8,
  localparam int CW = $clog2(MAX_WINDOWS),
  localparam int NW = CW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic [NW-1:0] win_cnt_i,
  input logic [CW-1:0] cwp_o,
  input logic [31:0]   psw_o,
  input logic          trap_valid_o,
  input logic [1:0]    trap_code_o
);

  a_r1_cwp_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    NW'(cwp_o) < win_cnt_i);

  a_r4_trap_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> ($stable(cwp_o) && $stable(psw_o)));

  a_r4_overflow_from_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && trap_code_o == 2'd2) |-> $past(cmd_valid_i && cmd_op_i == OP_SAVE));

  a_r5_illegal_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && trap_code_o == 2'd1)
      |-> $past(cmd_valid_i && (cmd_op_i == OP_RETT || cmd_op_i == OP_WR_PSW)));

  a_r6_et_rise_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psw_o[PSW_ET_BIT])
      |-> $past(cmd_valid_i && (cmd_op_i == OP_RETT || cmd_op_i == OP_WR_PSW)));

  a_r10_code_matches_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o == (trap_code_o != 2'd0));

  a_r11_idle_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> ($stable(psw_o) && !trap_valid_o));

endmodule

bind wptr_unit wptr_unit_chk #(.MAX_WINDOWS(MAX_WINDOWS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .win_cnt_i    (win_cnt_i),
  .cwp_o        (cwp_o),
  .psw_o        (psw_o),
  .trap_valid_o (trap_valid_o),
  .trap_code_o  (trap_code_o)
);

// File: tb/sim_wptr_unit.sv
`timescale 1ns/1ps
module sim_wptr_unit;

  localparam int         MAXW = 8;
  localparam int         CW   = $clog2(MAXW);
  localparam int         NW   = CW + 1;
  localparam logic [7:0] VER  = 8'hA5;

  // {op, wdata, expected cwp, expected trap code}
  localparam int NV = 15;
  localparam logic [44:0] VEC [NV] = '{
    {3'd0, 32'h0000_0000, 8'd7, 2'd0},  // R2 wrap 0 -> 7
    {3'd0, 32'h0000_0000, 8'd6, 2'd0},  // R2
    {3'd1, 32'h0000_0000, 8'd7, 2'd0},  // R3
    {3'd1, 32'h0000_0000, 8'd0, 2'd0},  // R3 wrap 7 -> 0
    {3'd4, 32'h0000_0002, 8'd0, 2'd0},  // R9 mark window 1
    {3'd1, 32'h0000_0000, 8'd0, 2'd3},  // R4 underflow
    {3'd0, 32'h0000_0000, 8'd7, 2'd0},  // R2
    {3'd4, 32'h0000_0040, 8'd7, 2'd0},  // R9 mark window 6
    {3'd0, 32'h0000_0000, 8'd7, 2'd2},  // R4 overflow
    {3'd4, 32'h0000_0000, 8'd7, 2'd0},  // R9 clear
    {3'd3, 32'h0000_0043, 8'd3, 2'd0},  // R7 cwp 3, PS=1, S=0
    {3'd2, 32'h0000_0000, 8'd4, 2'd0},  // R6 return from trap
    {3'd2, 32'h0000_0000, 8'd4, 2'd1},  // R5 ET already set
    {3'd3, 32'h0000_0008, 8'd4, 2'd1},  // R7 cwp field 8 out of range
    {3'd5, 32'hFFFF_FFFF, 8'd4, 2'd0}   // R11 undefined opcode
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [31:0]   wdata = '0;
  logic [NW-1:0] win_cnt = NW'(MAXW);
  logic [CW-1:0] cwp;
  logic [31:0]   psw;
  logic          trap_valid;
  logic [1:0]    trap_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wptr_unit #(.MAX_WINDOWS(MAXW), .VERSION(VER)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .wdata_i      (wdata),
    .win_cnt_i    (win_cnt),
    .cwp_o        (cwp),
    .psw_o        (psw),
    .trap_valid_o (trap_valid),
    .trap_code_o  (trap_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    wdata     = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic chk_trap(input string req, input logic [1:0] code);
    chk({req, " code"}, 32'(trap_code), 32'(code));
    chk({req, " valid"}, 32'(trap_valid), 32'(code != 2'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, held in reset
    chk("R1 cwp in reset", 32'(cwp), 32'd0);
    chk("R1 psw in reset", psw, 32'hA500_0080);
    chk("R1 trap in reset", 32'(trap_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 psw after release", psw, 32'hA500_0080);

    for (int i = 0; i < NV; i++) begin
      do_cmd(VEC[i][44:42], VEC[i][41:10]);
      chk($sformatf("R2/R3/R4 vec%0d cwp", i), 32'(cwp), 32'(VEC[i][9:2]));
      chk_trap($sformatf("R4/R5/R10 vec%0d", i), VEC[i][1:0]);
    end
    // R6: ET set, S copied from PS; R7 rejected write left it intact
    chk("R6 psw after return", psw, 32'hA500_00E4);

    // R7/R8 full field write with read-only bits set
    do_cmd(3'd3, 32'hFFBF_F7A2);
    chk_trap("R7 legal write", 2'd0);
    chk("R8 packed word", psw, 32'hA5B0_17A2);
    chk("R7 cwp", 32'(cwp), 32'd2);

    // R5 priority: ET=1 and target window invalid -> illegal
    do_cmd(3'd4, 32'h0000_0008);
    do_cmd(3'd2, 32'h0);
    chk_trap("R5 illegal over underflow", 2'd1);
    chk("R5 psw unchanged", psw, 32'hA5B0_17A2);

    // R6 underflow with ET=0: nothing changes
    do_cmd(3'd3, 32'h0000_0082);
    do_cmd(3'd2, 32'h0);
    chk_trap("R6 return underflow", 2'd3);
    chk("R6 psw unchanged", psw, 32'hA500_0082);
    @(negedge clk);
    chk_trap("R10 pulse ends", 2'd0);

    // R11 strobe low: no effect
    cmd_op = 3'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle cwp", 32'(cwp), 32'd2);
    chk_trap("R11 idle", 2'd0);

    // R12 reduced window count
    do_cmd(3'd4, 32'h0);
    do_cmd(3'd3, 32'h0000_0080);
    win_cnt = NW'(5);
    do_cmd(3'd0, 32'h0);
    chk("R12 save wraps to 4", 32'(cwp), 32'd4);
    do_cmd(3'd1, 32'h0);
    chk("R12 restore wraps to 0", 32'(cwp), 32'd0);
    do_cmd(3'd3, 32'h0000_0085);
    chk_trap("R12 cwp 5 rejected", 2'd1);
    chk("R12 cwp kept", 32'(cwp), 32'd0);
    do_cmd(3'd3, 32'h0000_0084);
    chk_trap("R12 cwp 4 accepted", 2'd0);
    do_cmd(3'd1, 32'h0);
    chk("R12 restore from 4", 32'(cwp), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule